// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-interrupt status of an 8-bit timer. Three sources feed it: a match against compare register A, a match against compare register B, and counter wrap. Each source raises a sticky flag when the timer core sends it a one-cycle event pulse. For the wrap source the event counts only while a qualifier input, derived from the active waveform mode, is high.

A flag can be cleared in two ways. Software can write a one to its bit through the register port, or the interrupt controller can pulse the acknowledge line of that source when it dispatches the vector. Each source drives its own request line, and that line is high only while its flag, its local enable and the global interrupt enable are all set. Vector prioritisation is handled outside this block.

Top module: `tmr_irq_flags`

## Requirements
- R1: After synchronous reset, the flag readback is 8'h00 and all three request lines are low.
- R2: A compare-A event pulse sets readback bit 4 at the next clock edge. The bit stays set until it is cleared.
- R3: A compare-B event pulse sets readback bit 3 at the next clock edge.
- R4: An overflow event pulse sets readback bit 1 at the next clock edge, but only if the overflow qualifier input is high in the same cycle. An event with the qualifier low leaves the bit unchanged.
- R5: When a write strobe carries a 1 in bit 4, 3 or 1 of the write data, that flag clears at the next edge. A 0 in a flag bit leaves that flag unchanged.
- R6: An acknowledge pulse for one source clears only that source's flag at the next edge.
- R7: A request output is high exactly when the global enable, that source's enable and that source's flag are all 1. The output is combinational from the registered flag.
- R8: If a set event and a clear (write-one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: Readback bits 7, 6, 5, 2 and 0 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtCmpA | input | 1 | Compare-A match pulse |
| evtCmpB | input | 1 | Compare-B match pulse |
| evtOvf | input | 1 | Counter wrap pulse |
| ovfQual | input | 1 | Mode qualifier; the wrap event counts only while this is high |
| wrEn | input | 1 | Flag register write strobe |
| wrData | input | 8 | Write data; a 1 in a flag bit clears that flag |
| ackCmpA | input | 1 | Compare-A vector taken |
| ackCmpB | input | 1 | Compare-B vector taken |
| ackOvf | input | 1 | Wrap vector taken |
| ieCmpA | input | 1 | Compare-A source enable |
| ieCmpB | input | 1 | Compare-B source enable |
| ieOvf | input | 1 | Wrap source enable |
| gie | input | 1 | Global interrupt enable |
| flagRd | output | 8 | Flag register readback |
| irqCmpA | output | 1 | Compare-A request |
| irqCmpB | output | 1 | Compare-B request |
| irqOvf | output | 1 | Wrap request |

## Verification
The hardest case to reach is a collision, where a set event meets a clear path in the same cycle. Neither the timer core nor the interrupt controller has any reason to line these up. The bench drives event, write-one and acknowledge together in single vector rows, for each source and for both clear paths. It then reads the flag back before anything else changes it. Qualifier-low wrap events, and writes of ones to the unused bit positions, are applied with flags both set and clear, so that a stray change would show up in the readback.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int NumSrc = 3;
  localparam int RegW   = 8;
  localparam int SrcCmpA = 0;
  localparam int SrcCmpB = 1;
  localparam int SrcOvf  = 2;
  // readback bit of each source; a neighbour decodes these positions
  localparam int BitCmpA = 4;
  localparam int BitCmpB = 3;
  localparam int BitOvf  = 1;

  typedef struct packed {
    logic [NumSrc-1:0] setStb;
    logic [NumSrc-1:0] clrStb;
  } flagCtl_t;

  function automatic int srcBit(input int s);
    case (s)
      SrcCmpA: return BitCmpA;
      SrcCmpB: return BitCmpB;
      default: return BitOvf;
    endcase
  endfunction
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NumSrc-1:0] evt,
  input  logic              ovfQual,
  input  logic              wrEn,
  input  logic [RegW-1:0]   wrData,
  input  logic [NumSrc-1:0] ack,
  output flagCtl_t          ctl
);
  logic [NumSrc-1:0] evtQual;
  logic [NumSrc-1:0] wrClr;

  always_comb begin
    evtQual         = evt;
    evtQual[SrcOvf] = evt[SrcOvf] & ovfQual;
  end

  for (genvar s = 0; s < NumSrc; s++) begin : g_clr
    assign wrClr[s] = wrEn & wrData[srcBit(s)];
  end

  assign ctl.setStb = evtQual;
  assign ctl.clrStb = wrClr | ack;

  // R4
  ovf_qual_chk: assert property (@(posedge clk) disable iff (rst)
    !ovfQual |-> !ctl.setStb[SrcOvf]);
endmodule

// File: rtl/tmr_irq_dpath.sv
module tmr_irq_dpath
  import tmr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  flagCtl_t          ctl,
  input  logic [NumSrc-1:0] ie,
  input  logic              gie,
  output logic [RegW-1:0]   flagRd,
  output logic [NumSrc-1:0] irq
);
  logic [NumSrc-1:0] flagQ;

  for (genvar s = 0; s < NumSrc; s++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                 flagQ[s] <= 1'b0;
      else if (ctl.setStb[s])  flagQ[s] <= 1'b1;
      else if (ctl.clrStb[s])  flagQ[s] <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      ctl.setStb[s] |=> flagQ[s]);
    // R5
    clr_only_chk: assert property (@(posedge clk) disable iff (rst)
      (ctl.clrStb[s] && !ctl.setStb[s]) |=> !flagQ[s]);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctl.setStb[s] && !ctl.clrStb[s]) |=> $stable(flagQ[s]));
  end

  always_comb begin
    flagRd = '0;
    for (int s = 0; s < NumSrc; s++) flagRd[srcBit(s)] = flagQ[s];
  end

  assign irq = flagQ & ie & {NumSrc{gie}};

  // R9
  unused_zero_chk: assert property (@(posedge clk)
    (flagRd & ~((RegW'(1) << BitCmpA) | (RegW'(1) << BitCmpB) | (RegW'(1) << BitOvf))) == '0);
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !gie |-> irq == '0);
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evtCmpA,
  input  logic       evtCmpB,
  input  logic       evtOvf,
  input  logic       ovfQual,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       ackCmpA,
  input  logic       ackCmpB,
  input  logic       ackOvf,
  input  logic       ieCmpA,
  input  logic       ieCmpB,
  input  logic       ieOvf,
  input  logic       gie,
  output logic [7:0] flagRd,
  output logic       irqCmpA,
  output logic       irqCmpB,
  output logic       irqOvf
);
  flagCtl_t          ctl;
  logic [NumSrc-1:0] irqV;

  tmr_irq_ctrl i_ctrl (
    .clk(clk), .rst(rst),
    .evt({evtOvf, evtCmpB, evtCmpA}), .ovfQual(ovfQual),
    .wrEn(wrEn), .wrData(wrData),
    .ack({ackOvf, ackCmpB, ackCmpA}),
    .ctl(ctl)
  );

  tmr_irq_dpath i_dpath (
    .clk(clk), .rst(rst), .ctl(ctl),
    .ie({ieOvf, ieCmpB, ieCmpA}), .gie(gie),
    .flagRd(flagRd), .irq(irqV)
  );

  assign irqCmpA = irqV[SrcCmpA];
  assign irqCmpB = irqV[SrcCmpB];
  assign irqOvf  = irqV[SrcOvf];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> flagRd == 8'h00);
  // R6
  ack_a_chk: assert property (@(posedge clk) disable iff (rst)
    (ackCmpA && !evtCmpA) |=> !flagRd[4]);
endmodule

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
  localparam int ClkPeriod = 10;

  logic clk = 0, rst = 1;
  logic evtCmpA = 0, evtCmpB = 0, evtOvf = 0, ovfQual = 0, wrEn = 0;
  logic [7:0] wrData = 0;
  logic ackCmpA = 0, ackCmpB = 0, ackOvf = 0;
  logic ieCmpA = 0, ieCmpB = 0, ieOvf = 0, gie = 0;
  logic [7:0] flagRd;
  logic irqCmpA, irqCmpB, irqOvf;

  int checks = 0, errors = 0;

  always #(ClkPeriod/2) clk = ~clk;

  tmr_irq_flags i_tmr_irq_flags (.*);

  // vector: evt{A,B,O}, qual, wrEn, wrData, ack{A,B,O}, expected flagRd
  typedef struct packed {
    logic [2:0] evt; logic qual; logic we; logic [7:0] wd;
    logic [2:0] ack; logic [7:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t Vecs [NV] = '{
    '{3'b100, 1'b0, 1'b0, 8'h00, 3'b000, 8'h10, 4'd2},  // R2 set A
    '{3'b010, 1'b0, 1'b0, 8'h00, 3'b000, 8'h18, 4'd3},  // R3 set B
    '{3'b001, 1'b0, 1'b0, 8'h00, 3'b000, 8'h18, 4'd4},  // R4 qual low
    '{3'b001, 1'b1, 1'b0, 8'h00, 3'b000, 8'h1A, 4'd4},  // R4 set O
    '{3'b000, 1'b0, 1'b1, 8'hE5, 3'b000, 8'h1A, 4'd9},  // R9 unused ones
    '{3'b000, 1'b0, 1'b1, 8'h08, 3'b000, 8'h12, 4'd5},  // R5 clear B
    '{3'b000, 1'b0, 1'b1, 8'h00, 3'b000, 8'h12, 4'd5},  // R5 zeros keep
    '{3'b000, 1'b0, 1'b0, 8'h00, 3'b100, 8'h02, 4'd6},  // R6 ack A
    '{3'b000, 1'b0, 1'b0, 8'h00, 3'b001, 8'h00, 4'd6},  // R6 ack O
    '{3'b100, 1'b0, 1'b1, 8'h10, 3'b000, 8'h10, 4'd8},  // R8 set vs write
    '{3'b010, 1'b0, 1'b0, 8'h00, 3'b010, 8'h18, 4'd8},  // R8 set vs ack
    '{3'b001, 1'b1, 1'b1, 8'h02, 3'b001, 8'h1A, 4'd8},  // R8 both clears
    '{3'b000, 1'b0, 1'b1, 8'hFF, 3'b000, 8'h00, 4'd5},  // R5 clear all
    '{3'b000, 1'b0, 1'b1, 8'hE5, 3'b000, 8'h00, 4'd9}   // R9 no effect
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #1; endtask

  task automatic setAll;
    evtCmpA = 1; evtCmpB = 1; evtOvf = 1; ovfQual = 1; tick;
    evtCmpA = 0; evtCmpB = 0; evtOvf = 0; ovfQual = 0;
  endtask

  initial begin
    #(ClkPeriod*5000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick; tick; rst = 0; #1;
    // R1
    chk("R1 flags", flagRd, 8'h00);
    chk("R1 irq", {5'b0, irqCmpA, irqCmpB, irqOvf}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      {evtCmpA, evtCmpB, evtOvf} = Vecs[i].evt;
      ovfQual = Vecs[i].qual; wrEn = Vecs[i].we; wrData = Vecs[i].wd;
      {ackCmpA, ackCmpB, ackOvf} = Vecs[i].ack;
      tick;
      {evtCmpA, evtCmpB, evtOvf, ovfQual, wrEn, ackCmpA, ackCmpB, ackOvf} = '0;
      wrData = 0;
      chk($sformatf("R%0d vec %0d", Vecs[i].req, i), flagRd, Vecs[i].exp);
    end

    // R2: flag holds over idle cycles
    setAll; tick; tick;
    chk("R2 hold", flagRd, 8'h1A);

    // R7 gating
    gie = 1; ieCmpA = 1; ieCmpB = 0; ieOvf = 1; #1;
    chk("R7 partial enable", {5'b0, irqCmpA, irqCmpB, irqOvf}, 8'h05);
    gie = 0; #1;
    chk("R7 global off", {5'b0, irqCmpA, irqCmpB, irqOvf}, 8'h00);
    gie = 1; ieCmpB = 1; #1;
    chk("R7 all on", {5'b0, irqCmpA, irqCmpB, irqOvf}, 8'h07);
    ackCmpB = 1; tick; ackCmpB = 0;
    chk("R7 flag clear drops irq", {5'b0, irqCmpA, irqCmpB, irqOvf}, 8'h05);
    chk("R6 ack B only", flagRd, 8'h12);

    // R1: reset with flags set
    rst = 1; tick; rst = 0; #1;
    chk("R1 reset clears", flagRd, 8'h00);
    chk("R1 irq after reset", {5'b0, irqCmpA, irqCmpB, irqOvf}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule